// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is one 16-bit output-compare channel. A compare value held in the channel is checked every clock against the count of one of two free-running timers, picked by a select input. When the selected count first becomes equal to the compare value, the channel acts according to a 4-bit mode. It can set, clear or toggle its own compare output latch. It can raise only its interrupt flag. Or it can issue a special event that resets the selected timer, which turns the compare value into a programmable timer period.

In special-event mode, an instance built as the converter-capable channel also pulses an A/D start request, provided the converter reports itself enabled. The compare latch drives the pad value only in the three pin-action modes. In every other mode the pad value follows the general-purpose I/O latch input. Pad direction always comes from an external output-enable input. The interrupt flag is sticky until software clears it. The interrupt request is the flag gated by the interrupt enable.

Top module: `oc_channel`

## Requirements
- R1: After synchronous active-low reset the mode is off (4'b0000), the compare latch is 0, the interrupt flag and request are 0, and the timer-reset and A/D start outputs are 0.
- R2: In mode 4'b1000 a match sets the compare latch to 1 on the following clock edge and sets the interrupt flag.
- R3: In mode 4'b1001 a match clears the compare latch to 0 on the following clock edge and sets the interrupt flag.
- R4: In mode 4'b0010 each match inverts the compare latch on the following clock edge and sets the interrupt flag.
- R5: A match is the first cycle in which the selected count equals the compare value; a count held at that value does not trigger again.
- R6: In mode 4'b1010 a match sets only the interrupt flag; the compare latch keeps its value and the pad value follows the I/O latch input.
- R7: In mode 4'b1011 a match pulses bit N of the timer-reset output (N = selected timer) for that same cycle only, and pulses the A/D start output in that cycle when the channel is converter-capable and the converter-enabled input is 1.
- R8: Only the timer picked by the select input (0 = first count, 1 = second count) is compared; equality on the other timer has no effect.
- R9: Writing mode 4'b0000 clears the compare latch to 0 on the write's clock edge.
- R10: The interrupt flag stays 1 until a clear strobe; the interrupt request is 1 exactly when the flag and the interrupt enable are both 1.
- R11: The pad output-enable equals the external output-enable input; the pad value is the compare latch in modes 4'b1000, 4'b1001 and 4'b0010, and the I/O latch input otherwise.
- R12: Any mode encoding other than the five listed above produces no flag, no latch change and no timer-reset or A/D pulse on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_mode | input | 4 | Mode value to write |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_data | input | 16 | Compare value to write |
| tmr_sel | input | 1 | Timer select (0 = first, 1 = second) |
| tmr_cnt | input | 32 | Timer counts, first timer in bits 15:0 |
| adc_en | input | 1 | Converter is enabled |
| io_latch | input | 1 | General-purpose I/O data latch value |
| out_en | input | 1 | Pad direction: 1 = output |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| pad_o | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |
| tmr_clr | output | 2 | Per-timer single-cycle reset pulse |
| adc_start | output | 1 | Single-cycle A/D start request |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Each pin-action mode is driven with a count that steps onto the compare value from below. This shows set, clear and invert apart by the latch value seen on the pad afterwards. The count is then held on the compare value for several cycles, which separates an edge-detected match from a level one through both the latch and a re-cleared flag. Equality is placed on the unselected timer before the select is switched, which shows which count feeds the comparator. Software-interrupt, off and unused encodings are followed by a switch into toggle mode without a match, so that the hidden latch value becomes visible at the pad. Special-event matches are tried with each timer selected and with the converter enable both low and high.

// File: rtl/oc_pkg.sv
// Package: shared mode encodings and decode helpers for the output-compare channel.
// Assumes the 4-bit mode encodings below are fixed by software convention.
package oc_pkg;

    localparam logic [3:0] MODE_OFF    = 4'b0000;
    localparam logic [3:0] MODE_TOGGLE = 4'b0010;
    localparam logic [3:0] MODE_SET    = 4'b1000;
    localparam logic [3:0] MODE_CLR    = 4'b1001;
    localparam logic [3:0] MODE_SWINT  = 4'b1010;
    localparam logic [3:0] MODE_EVENT  = 4'b1011;

    // True for encodings that react to a match at all.
    function automatic logic mode_active(input logic [3:0] m);
        return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLR) ||
               (m == MODE_SWINT)  || (m == MODE_EVENT);
    endfunction

    // True for encodings in which the compare latch owns the pad value.
    function automatic logic mode_drives_pin(input logic [3:0] m);
        return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLR);
    endfunction

endpackage

// File: rtl/oc_match.sv
// Module: holds the compare value, selects one timer count and produces a
// single-cycle match pulse on the first cycle of equality.
// Assumes timer counts are synchronous to clk.
module oc_match #(
    parameter int W       = 16,
    parameter int NUM_TMR = 2,
    localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmp_wr,
    input  logic [W-1:0]              cmp_data,
    input  logic [SEL_W-1:0]          tmr_sel,
    input  logic [NUM_TMR-1:0][W-1:0] tmr_cnt,
    output logic                      match
);

    logic [W-1:0] cmp_q;
    logic [W-1:0] cnt_sel;
    logic         eq;
    logic         eq_q;

    // Compare value register, loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= cmp_data;
    end

    // Pick the selected timer count and compare it.
    always_comb begin
        cnt_sel = tmr_cnt[tmr_sel];
        eq      = (cnt_sel == cmp_q);
    end

    // Remember last cycle's equality for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    assign match = eq && !eq_q;

    // R5: a match never lasts two cycles in a row.
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);

endmodule

// File: rtl/oc_action.sv
// Module: mode register, compare output latch, pad mux and event pulses.
// Assumes match is a single-cycle pulse from oc_match.
module oc_action
    import oc_pkg::*;
#(
    parameter int  NUM_TMR     = 2,
    parameter bit  ADC_CAPABLE = 1'b1,
    localparam int SEL_W       = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [3:0]         cfg_mode,
    input  logic               match,
    input  logic [SEL_W-1:0]   tmr_sel,
    input  logic               adc_en,
    input  logic               io_latch,
    input  logic               out_en,
    output logic               pad_o,
    output logic               pad_oe,
    output logic [NUM_TMR-1:0] tmr_clr,
    output logic               adc_start,
    output logic               flag_set
);

    logic [3:0] mode_q;
    logic       latch_q;
    logic       evt;

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MODE_OFF;
        else if (cfg_wr) mode_q <= cfg_mode;
    end

    // Compare output latch: cleared by an all-zero mode write, else updated on match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (cfg_wr && (cfg_mode == MODE_OFF)) begin
            latch_q <= 1'b0;
        end else if (match) begin
            case (mode_q)
                MODE_SET:    latch_q <= 1'b1;
                MODE_CLR:    latch_q <= 1'b0;
                MODE_TOGGLE: latch_q <= !latch_q;
                default:     latch_q <= latch_q;
            endcase
        end
    end

    // Pad mux and direction.
    always_comb begin
        pad_o  = mode_drives_pin(mode_q) ? latch_q : io_latch;
        pad_oe = out_en;
    end

    assign flag_set = match && mode_active(mode_q);
    assign evt      = match && (mode_q == MODE_EVENT);

    // Per-timer reset pulse to the selected timer only.
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tclr
        assign tmr_clr[i] = evt && (tmr_sel == SEL_W'(i));
    end

    // Converter start exists only on the converter-capable variant.
    if (ADC_CAPABLE) begin : g_adc
        assign adc_start = evt && adc_en;
    end else begin : g_no_adc
        assign adc_start = 1'b0;
    end

    p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cfg_wr && mode_q == MODE_SET) |=> latch_q);
    p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cfg_wr && mode_q == MODE_CLR) |=> !latch_q);
    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cfg_wr && mode_q == MODE_TOGGLE) |=> (latch_q != $past(latch_q)));
    p_no_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cfg_wr && mode_q == MODE_SWINT) |=> $stable(latch_q));
    p_tclr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_clr));
    p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_mode == MODE_OFF) |=> !latch_q);

endmodule

// File: rtl/oc_irq.sv
// Module: sticky interrupt flag and gated interrupt request.
// Assumes a set and a clear in the same cycle resolve as set.
module oc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_set,
    input  logic flag_clr,
    input  logic irq_en,
    output logic irq_flag,
    output logic irq_req
);

    // Flag register: set by match, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (flag_set) irq_flag <= 1'b1;
        else if (flag_clr) irq_flag <= 1'b0;
    end

    assign irq_req = irq_flag && irq_en;

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);
    p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> irq_flag);

endmodule

// File: rtl/oc_channel.sv
// Module: top of one output-compare channel.
// Assumes both timer counts are synchronous free-running counts on clk.
module oc_channel #(
    parameter int  W           = 16,
    parameter int  NUM_TMR     = 2,
    parameter bit  ADC_CAPABLE = 1'b1,
    localparam int SEL_W       = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [3:0]                cfg_mode,
    input  logic                      cmp_wr,
    input  logic [W-1:0]              cmp_data,
    input  logic [SEL_W-1:0]          tmr_sel,
    input  logic [NUM_TMR-1:0][W-1:0] tmr_cnt,
    input  logic                      adc_en,
    input  logic                      io_latch,
    input  logic                      out_en,
    input  logic                      flag_clr,
    input  logic                      irq_en,
    output logic                      pad_o,
    output logic                      pad_oe,
    output logic [NUM_TMR-1:0]        tmr_clr,
    output logic                      adc_start,
    output logic                      irq_flag,
    output logic                      irq_req
);

    logic match;
    logic flag_set;

    oc_match #(.W(W), .NUM_TMR(NUM_TMR)) u_match (
        .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
        .tmr_sel(tmr_sel), .tmr_cnt(tmr_cnt), .match(match)
    );

    oc_action #(.NUM_TMR(NUM_TMR), .ADC_CAPABLE(ADC_CAPABLE)) u_action (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .match(match), .tmr_sel(tmr_sel), .adc_en(adc_en), .io_latch(io_latch),
        .out_en(out_en), .pad_o(pad_o), .pad_oe(pad_oe), .tmr_clr(tmr_clr),
        .adc_start(adc_start), .flag_set(flag_set)
    );

    oc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
        .irq_en(irq_en), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    // R11: pad direction always tracks the external enable.
    p_oe_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == out_en);

endmodule

// File: tb/oc_channel_bench.sv
module oc_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [3:0]  cfg_mode;
    logic        cmp_wr;
    logic [15:0] cmp_data;
    logic        tmr_sel;
    logic [1:0][15:0] tmr_cnt;
    logic        adc_en, io_latch, out_en, flag_clr, irq_en;
    logic        pad_o, pad_oe, adc_start, irq_flag, irq_req;
    logic [1:0]  tmr_clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    oc_channel u_oc_channel (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data), .tmr_sel(tmr_sel), .tmr_cnt(tmr_cnt),
        .adc_en(adc_en), .io_latch(io_latch), .out_en(out_en), .flag_clr(flag_clr),
        .irq_en(irq_en), .pad_o(pad_o), .pad_oe(pad_oe), .tmr_clr(tmr_clr),
        .adc_start(adc_start), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        cfg_wr = 1'b1; cfg_mode = m; tick(); cfg_wr = 1'b0;
    endtask

    task automatic set_cmp(input logic [15:0] v);
        cmp_wr = 1'b1; cmp_data = v; tick(); cmp_wr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick();
        chk("R1", "flag", {3'b0, irq_flag}, 4'd0);
        chk("R1", "req", {3'b0, irq_req}, 4'd0);
        chk("R1", "tclr", {2'b0, tmr_clr}, 4'd0);
        chk("R1", "adc", {3'b0, adc_start}, 4'd0);
        chk("R1", "pad follows io in off mode", {3'b0, pad_o}, {3'b0, io_latch});
        rst_n = 1'b1; tick();
        set_mode(4'b0010);
        chk("R1", "latch 0 after reset", {3'b0, pad_o}, 4'd0);
        set_mode(4'b0000);
    endtask

    task automatic t_set_high();
        tmr_sel = 1'b0; tmr_cnt[0] = 16'd0; tmr_cnt[1] = 16'd0; io_latch = 1'b1;
        set_cmp(16'd100);
        set_mode(4'b1000);
        chk("R2", "pad before match", {3'b0, pad_o}, 4'd0);
        tmr_cnt[0] = 16'd100; tick();
        chk("R2", "pad after match", {3'b0, pad_o}, 4'd1);
        chk("R2", "flag after match", {3'b0, irq_flag}, 4'd1);
        irq_en = 1'b0; #1;
        chk("R10", "req with enable low", {3'b0, irq_req}, 4'd0);
        irq_en = 1'b1; #1;
        chk("R10", "req with enable high", {3'b0, irq_req}, 4'd1);
        tick();
        chk("R10", "flag sticky", {3'b0, irq_flag}, 4'd1);
        clear_flag();
        chk("R10", "flag cleared", {3'b0, irq_flag}, 4'd0);
        irq_en = 1'b0;
        tmr_cnt[0] = 16'd0; tick();
    endtask

    task automatic t_clr_low();
        set_mode(4'b1001);
        chk("R3", "pad before match", {3'b0, pad_o}, 4'd1);
        tmr_cnt[0] = 16'd100; tick();
        chk("R3", "pad after match", {3'b0, pad_o}, 4'd0);
        chk("R3", "flag after match", {3'b0, irq_flag}, 4'd1);
        clear_flag();
        tmr_cnt[0] = 16'd0; tick();
    endtask

    task automatic t_toggle_hold();
        set_mode(4'b0010);
        chk("R4", "pad before match", {3'b0, pad_o}, 4'd0);
        tmr_cnt[0] = 16'd100; tick();
        chk("R4", "first toggle", {3'b0, pad_o}, 4'd1);
        clear_flag();
        tick(); tick(); tick();
        chk("R5", "held count no retoggle", {3'b0, pad_o}, 4'd1);
        chk("R5", "held count no reflag", {3'b0, irq_flag}, 4'd0);
        tmr_cnt[0] = 16'd0; tick();
        tmr_cnt[0] = 16'd100; tick();
        chk("R4", "second toggle", {3'b0, pad_o}, 4'd0);
        clear_flag();
        tmr_cnt[0] = 16'd5; tick();
    endtask

    task automatic t_select();
        tmr_cnt[1] = 16'd100; tick(); tick();
        chk("R8", "unselected equality ignored pad", {3'b0, pad_o}, 4'd0);
        chk("R8", "unselected equality ignored flag", {3'b0, irq_flag}, 4'd0);
        tmr_sel = 1'b1; tick();
        chk("R8", "selected timer matches", {3'b0, pad_o}, 4'd1);
        clear_flag();
        tmr_cnt[1] = 16'd0; tick();
    endtask

    task automatic t_swint();
        set_mode(4'b1010);
        io_latch = 1'b0; #1;
        chk("R6", "pad follows io latch 0", {3'b0, pad_o}, 4'd0);
        io_latch = 1'b1; #1;
        chk("R11", "pad follows io latch 1", {3'b0, pad_o}, 4'd1);
        io_latch = 1'b0;
        tmr_cnt[1] = 16'd100; tick();
        chk("R6", "flag set", {3'b0, irq_flag}, 4'd1);
        chk("R6", "pad still io latch", {3'b0, pad_o}, 4'd0);
        set_mode(4'b0010);
        chk("R6", "latch unchanged", {3'b0, pad_o}, 4'd1);
        clear_flag();
        tmr_cnt[1] = 16'd0; tick();
    endtask

    task automatic t_event();
        set_mode(4'b1011);
        adc_en = 1'b0;
        tmr_cnt[1] = 16'd100; #1;
        chk("R7", "tclr on timer 1", {2'b0, tmr_clr}, 4'b0010);
        chk("R7", "no adc when disabled", {3'b0, adc_start}, 4'd0);
        tick();
        chk("R7", "tclr single cycle", {2'b0, tmr_clr}, 4'd0);
        chk("R7", "flag set", {3'b0, irq_flag}, 4'd1);
        tmr_cnt[1] = 16'd0; tick();
        adc_en = 1'b1;
        tmr_cnt[1] = 16'd100; #1;
        chk("R7", "adc start when enabled", {3'b0, adc_start}, 4'd1);
        tick();
        chk("R7", "adc single cycle", {3'b0, adc_start}, 4'd0);
        tmr_sel = 1'b0; tmr_cnt[0] = 16'd0; tick();
        tmr_cnt[0] = 16'd100; #1;
        chk("R7", "tclr on timer 0", {2'b0, tmr_clr}, 4'b0001);
        tick();
        adc_en = 1'b0;
        clear_flag();
    endtask

    task automatic t_off_clear();
        tmr_cnt[0] = 16'd0;
        set_mode(4'b1000);
        tmr_cnt[0] = 16'd100; tick();
        chk("R9", "latch set first", {3'b0, pad_o}, 4'd1);
        set_mode(4'b0000);
        set_mode(4'b0010);
        chk("R9", "off write cleared latch", {3'b0, pad_o}, 4'd0);
        clear_flag();
    endtask

    task automatic t_unused();
        set_mode(4'b0101);
        tmr_cnt[0] = 16'd0; tick();
        tmr_cnt[0] = 16'd100; #1;
        chk("R12", "no tclr", {2'b0, tmr_clr}, 4'd0);
        tick();
        chk("R12", "no flag", {3'b0, irq_flag}, 4'd0);
        set_mode(4'b0010);
        chk("R12", "latch unchanged", {3'b0, pad_o}, 4'd0);
    endtask

    task automatic t_oe();
        out_en = 1'b0; #1;
        chk("R11", "oe low", {3'b0, pad_oe}, 4'd0);
        out_en = 1'b1; #1;
        chk("R11", "oe high", {3'b0, pad_oe}, 4'd1);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_mode = 4'd0; cmp_wr = 1'b0; cmp_data = 16'd0;
        tmr_sel = 1'b0; tmr_cnt = '0; adc_en = 1'b0; io_latch = 1'b0; out_en = 1'b0;
        flag_clr = 1'b0; irq_en = 1'b0;
        @(negedge clk);
        t_reset();
        t_set_high();
        t_clr_low();
        t_toggle_hold();
        t_select();
        t_swint();
        t_event();
        t_off_clear();
        t_unused();
        t_oe();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule